// File: doc/BRIEF.md
# DMA Channel Register Decoder

This block is the register-access front end of a sixteen-channel DMA engine. It takes two independent 32-bit slave ports and turns each access into a per-channel select, a register offset, a write strobe and write data, which fan out to the channel banks. It gathers their read data into one registered response per port. The channels themselves are not part of this block. They return read data combinationally for whatever offset they are handed, and each one raises a level interrupt flag.

The main port covers a 4 KB window. Offsets below 0xF00 are split into a channel number (address bits 11:8) and a register offset (bits 7:0), which reaches channels 0 to 14. Two global registers also sit in this window. At 0xFE0 is a read-only view of all sixteen interrupt flags. At 0xFF0 is a channel-enable register that resets to all ones and is driven out to the engine. The second port covers a 256-byte window that always addresses channel 15, using its bits 7:0 as the register offset. The two ports never reach the same channel, so they can both be active in the same cycle with no arbitration.

Each channel bank holds nine word registers at offsets 0x00 to 0x20. Only the control word (0x00), the descriptor pointer (0x04) and the debug word (0x20) accept writes. The other six are read-only, and a write to one of them is dropped before it reaches the channel. Only full-word accesses are honoured.

Top module: `dma_reg_decode`

## Requirements
- R1: After reset `a_rdata` and `b_rdata` are 0, `chan_en` is 0xFFFF, and no `ch_sel` or `ch_wr` bit is set while no port is accessed.
- R2: A full-word access on the main port to an offset below 0xF00, whose low byte is word aligned and at most 0x20, raises only `ch_sel[addr[11:8]]` in the same cycle. That channel's `ch_off` slice equals `addr[7:0]` and its `ch_wdata` slice equals `a_wdata`.
- R3: `ch_wr[n]` rises with `ch_sel[n]` only on a write to register offset 0x00, 0x04 or 0x20. Writes to offsets 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C select the channel but raise no write strobe.
- R4: A read accepted on a port at clock edge k shows the selected channel's `ch_rdata` word on that port's read-data output from edge k onward. The output holds until the next read.
- R5: A read of main offset 0xFE0 returns `ch_irq` zero-extended in bit positions 15:0, with bit n belonging to channel n. A write to 0xFE0 changes neither this value nor `chan_en`.
- R6: A full-word write to main offset 0xFF0 loads `a_wdata[15:0]` into `chan_en` at the next edge. A read of 0xFF0 returns `chan_en` zero-extended.
- R7: Every mapped full-word access on the second port raises only `ch_sel[15]`, with `ch_off[15]` equal to `b_addr` and read data taken from channel 15.
- R8: An access whose byte enables are not all ones selects no channel, writes nothing, and reads back 0.
- R9: Any other offset reads 0 and selects no channel. This covers a register offset above 0x20 or not word aligned on either port, and any main offset at or above 0xF00 other than 0xFE0 and 0xFF0.
- R10: `irq_any` is high exactly when at least one `ch_irq` bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_sel | input | 1 | Main port access valid this cycle |
| a_wr | input | 1 | Main port write (1) or read (0) |
| a_addr | input | 12 | Main port byte offset |
| a_be | input | 4 | Main port byte enables |
| a_wdata | input | 32 | Main port write data |
| a_rdata | output | 32 | Main port registered read data |
| b_sel | input | 1 | Channel-15 port access valid |
| b_wr | input | 1 | Channel-15 port write (1) or read (0) |
| b_addr | input | 8 | Channel-15 port byte offset |
| b_be | input | 4 | Channel-15 port byte enables |
| b_wdata | input | 32 | Channel-15 port write data |
| b_rdata | output | 32 | Channel-15 port registered read data |
| ch_sel | output | 16 | Per-channel register select |
| ch_wr | output | 16 | Per-channel write strobe |
| ch_off | output | 128 | Per-channel register offset, 8 bits each, channel n at bits 8n+7:8n |
| ch_wdata | output | 512 | Per-channel write data, 32 bits each |
| ch_rdata | input | 512 | Per-channel read data, 32 bits each |
| ch_irq | input | 16 | Per-channel interrupt flag |
| chan_en | output | 16 | Global channel enable bits |
| irq_any | output | 1 | OR of all channel interrupt flags |

## Verification
The assertions assume that each port holds `sel`, `wr`, address, byte enables and data steady for a whole cycle. They also assume that `ch_irq` changes only between accesses, so that the value seen at the read edge is the value sampled. The bench changes every input at the falling edge and changes `ch_irq` only while both ports are idle. Its channel model returns a word built from the channel number and the offset it receives, which makes any wrong routing show up in the read data. One case drives both ports in the same cycle to exercise their independence.

// File: rtl/dma_reg_decode.sv
module dma_reg_decode #(
  parameter int NCH    = 16,
  parameter int DW     = 32,
  parameter int WIN_AW = 12,
  parameter int REG_AW = 8,
  parameter logic [WIN_AW-1:0] GLOBAL_BASE = 12'hF00,
  parameter logic [WIN_AW-1:0] IRQ_OFF     = 12'hFE0,
  parameter logic [WIN_AW-1:0] EN_OFF      = 12'hFF0,
  parameter logic [REG_AW-1:0] LAST_REG    = 8'h20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  a_sel,
  input  logic                  a_wr,
  input  logic [WIN_AW-1:0]     a_addr,
  input  logic [DW/8-1:0]       a_be,
  input  logic [DW-1:0]         a_wdata,
  output logic [DW-1:0]         a_rdata,
  input  logic                  b_sel,
  input  logic                  b_wr,
  input  logic [REG_AW-1:0]     b_addr,
  input  logic [DW/8-1:0]       b_be,
  input  logic [DW-1:0]         b_wdata,
  output logic [DW-1:0]         b_rdata,
  output logic [NCH-1:0]        ch_sel,
  output logic [NCH-1:0]        ch_wr,
  output logic [NCH*REG_AW-1:0] ch_off,
  output logic [NCH*DW-1:0]     ch_wdata,
  input  logic [NCH*DW-1:0]     ch_rdata,
  input  logic [NCH-1:0]        ch_irq,
  output logic [NCH-1:0]        chan_en,
  output logic                  irq_any
);

  localparam int CHW = $clog2(NCH);
  localparam int HI  = NCH - 1;

  function automatic logic reg_mapped(input logic [REG_AW-1:0] r);
    return (r[1:0] == 2'b00) && (r <= LAST_REG);
  endfunction

  function automatic logic reg_writable(input logic [REG_AW-1:0] r);
    return (r == '0) || (r == REG_AW'(4)) || (r == LAST_REG);
  endfunction

  logic              a_full, b_full, a_hit, b_hit;
  logic [CHW-1:0]    a_chn;
  logic [REG_AW-1:0] a_reg;
  logic [DW-1:0]     a_next, b_next;

  assign a_full = a_sel && (a_be == '1);
  assign b_full = b_sel && (b_be == '1);
  assign a_chn  = a_addr[REG_AW +: CHW];
  assign a_reg  = a_addr[REG_AW-1:0];
  assign a_hit  = a_full && (a_addr < GLOBAL_BASE) && reg_mapped(a_reg);
  assign b_hit  = b_full && reg_mapped(b_addr);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    if (c == HI) begin : g_dedicated
      assign ch_sel[c] = b_hit;
      assign ch_wr[c]  = b_hit && b_wr && reg_writable(b_addr);
      assign ch_off[c*REG_AW +: REG_AW] = b_addr;
      assign ch_wdata[c*DW +: DW] = b_wdata;
    end else begin : g_shared
      assign ch_sel[c] = a_hit && (a_chn == CHW'(c));
      assign ch_wr[c]  = ch_sel[c] && a_wr && reg_writable(a_reg);
      assign ch_off[c*REG_AW +: REG_AW] = a_reg;
      assign ch_wdata[c*DW +: DW] = a_wdata;
    end
  end

  always_comb begin
    a_next = '0;
    if (a_hit)
      a_next = ch_rdata[a_chn*DW +: DW];
    else if (a_full && a_addr == IRQ_OFF)
      a_next = DW'(ch_irq);
    else if (a_full && a_addr == EN_OFF)
      a_next = DW'(chan_en);
  end

  assign b_next  = b_hit ? ch_rdata[HI*DW +: DW] : '0;
  assign irq_any = |ch_irq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_rdata <= '0;
      b_rdata <= '0;
      chan_en <= '1;
    end else begin
      if (a_sel && !a_wr) a_rdata <= a_next;
      if (b_sel && !b_wr) b_rdata <= b_next;
      if (a_full && a_wr && a_addr == EN_OFF) chan_en <= a_wdata[NCH-1:0];
    end
  end

endmodule

module dma_reg_decode_chk #(
  parameter int NCH    = 16,
  parameter int DW     = 32,
  parameter int WIN_AW = 12,
  parameter logic [WIN_AW-1:0] IRQ_OFF = 12'hFE0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              a_sel,
  input logic              a_wr,
  input logic [WIN_AW-1:0] a_addr,
  input logic [DW/8-1:0]   a_be,
  input logic              b_sel,
  input logic [NCH-1:0]    ch_sel,
  input logic [NCH-1:0]    ch_wr,
  input logic [NCH-1:0]    ch_irq,
  input logic [DW-1:0]     a_rdata,
  input logic [NCH-1:0]    chan_en
);

  // R2
  main_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_sel[NCH-2:0]));

  // R3
  wr_within_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_wr & ~ch_sel) == '0);

  // R7
  hi_from_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_sel[NCH-1] |-> b_sel);

  // R8
  partial_nosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_be != '1) |-> (ch_sel[NCH-2:0] == '0));

  // R8
  partial_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_sel && !a_wr && a_be != '1) |=> (a_rdata == '0));

  // R5
  irq_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_sel && !a_wr && a_be == '1 && a_addr == IRQ_OFF) |=> (a_rdata == DW'($past(ch_irq))));

  // R6
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_sel && a_wr) |=> $stable(chan_en));

endmodule

bind dma_reg_decode dma_reg_decode_chk #(.NCH(NCH), .DW(DW), .WIN_AW(WIN_AW), .IRQ_OFF(IRQ_OFF)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_sel(a_sel), .a_wr(a_wr), .a_addr(a_addr), .a_be(a_be),
  .b_sel(b_sel), .ch_sel(ch_sel), .ch_wr(ch_wr), .ch_irq(ch_irq), .a_rdata(a_rdata),
  .chan_en(chan_en)
);

// File: tb/tb_dma_reg_decode.sv
`timescale 1ns/1ps
module tb_dma_reg_decode;
  localparam int NCH = 16;
  localparam int DW  = 32;

  logic clk = 0, rst_n = 0;
  logic a_sel = 0, a_wr = 0, b_sel = 0, b_wr = 0;
  logic [11:0] a_addr = '0;
  logic [7:0]  b_addr = '0;
  logic [3:0]  a_be = '0, b_be = '0;
  logic [31:0] a_wdata = '0, b_wdata = '0, a_rdata, b_rdata;
  logic [NCH-1:0] ch_sel, ch_wr, ch_irq = '0, chan_en;
  logic [NCH*8-1:0]  ch_off;
  logic [NCH*DW-1:0] ch_wdata, ch_rdata;
  logic irq_any;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] qa_exp[$], qb_exp[$];
  string qa_tag[$], qb_tag[$];
  logic a_rd_d = 0, b_rd_d = 0;

  always #2 clk = ~clk;

  dma_reg_decode dut (
    .clk(clk), .rst_n(rst_n),
    .a_sel(a_sel), .a_wr(a_wr), .a_addr(a_addr), .a_be(a_be), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_sel(b_sel), .b_wr(b_wr), .b_addr(b_addr), .b_be(b_be), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .ch_sel(ch_sel), .ch_wr(ch_wr), .ch_off(ch_off), .ch_wdata(ch_wdata), .ch_rdata(ch_rdata),
    .ch_irq(ch_irq), .chan_en(chan_en), .irq_any(irq_any)
  );

  // channel model: word = {channel, 16'h5A00, offset seen}
  always_comb
    for (int c = 0; c < NCH; c++)
      ch_rdata[c*DW +: DW] = {8'(c), 16'h5A00, ch_off[c*8 +: 8]};

  function automatic logic [31:0] cw(input int c, input logic [7:0] off);
    return {8'(c), 16'h5A00, off};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    a_rd_d <= rst_n && a_sel && !a_wr;
    b_rd_d <= rst_n && b_sel && !b_wr;
  end

  always @(negedge clk) begin
    if (a_rd_d) begin
      if (qa_exp.size() == 0) chk("R4 main-port read with nothing expected", 32'h1, 32'h0);
      else chk(qa_tag.pop_front(), a_rdata, qa_exp.pop_front());
    end
    if (b_rd_d) begin
      if (qb_exp.size() == 0) chk("R4 ch15-port read with nothing expected", 32'h1, 32'h0);
      else chk(qb_tag.pop_front(), b_rdata, qb_exp.pop_front());
    end
  end

  task automatic drive_a(input bit wr, input logic [11:0] addr, input logic [3:0] be,
                         input logic [31:0] wd, input logic [31:0] exp, input string tag);
    @(negedge clk);
    a_sel = 1; a_wr = wr; a_addr = addr; a_be = be; a_wdata = wd;
    if (!wr) begin qa_exp.push_back(exp); qa_tag.push_back(tag); end
    #1;
  endtask

  task automatic drive_b(input bit wr, input logic [7:0] addr, input logic [3:0] be,
                         input logic [31:0] wd, input logic [31:0] exp, input string tag);
    @(negedge clk);
    b_sel = 1; b_wr = wr; b_addr = addr; b_be = be; b_wdata = wd;
    if (!wr) begin qb_exp.push_back(exp); qb_tag.push_back(tag); end
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    a_sel = 0; a_wr = 0; a_be = '0; b_sel = 0; b_wr = 0; b_be = '0;
    #1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 a_rdata after reset", a_rdata, 0);
    chk("R1 b_rdata after reset", b_rdata, 0);
    chk("R1 chan_en after reset", 32'(chan_en), 32'hFFFF);
    chk("R1 no select idle", 32'(ch_sel), 0);
    chk("R1 no write idle", 32'(ch_wr), 0);

    // R2 R4 main port reads
    drive_a(0, 12'h314, 4'hF, 0, cw(3, 8'h14), "R4 ch3 length read");
    chk("R2 ch3 select", 32'(ch_sel), 32'h0008);
    chk("R2 ch3 offset", 32'(ch_off[3*8 +: 8]), 32'h14);
    idle();
    drive_a(0, 12'hE20, 4'hF, 0, cw(14, 8'h20), "R4 ch14 debug read");
    chk("R2 ch14 select", 32'(ch_sel), 32'h4000);
    idle();
    drive_a(0, 12'h000, 4'hF, 0, cw(0, 8'h00), "R4 ch0 control read");
    idle();

    // R3 write strobes
    drive_a(1, 12'h504, 4'hF, 32'hDEAD_0504, 0, "");
    chk("R3 ch5 ptr write strobe", 32'(ch_wr), 32'h0020);
    chk("R2 ch5 wdata", ch_wdata[5*DW +: DW], 32'hDEAD_0504);
    idle();
    drive_a(1, 12'h50C, 4'hF, 32'h1111_2222, 0, "");
    chk("R3 read-only source no strobe", 32'(ch_wr), 0);
    chk("R3 read-only still selects", 32'(ch_sel), 32'h0020);
    idle();
    drive_a(1, 12'h220, 4'hF, 32'h0BAD_F00D, 0, "");
    chk("R3 ch2 debug write strobe", 32'(ch_wr), 32'h0004);
    idle();

    // R7 dedicated port
    drive_b(0, 8'h18, 4'hF, 0, cw(15, 8'h18), "R7 ch15 stride read");
    chk("R7 ch15 select", 32'(ch_sel), 32'h8000);
    chk("R7 ch15 offset", 32'(ch_off[15*8 +: 8]), 32'h18);
    idle();
    drive_b(1, 8'h00, 4'hF, 32'h0000_0001, 0, "");
    chk("R7 ch15 control write", 32'(ch_wr), 32'h8000);
    chk("R7 ch15 wdata", ch_wdata[15*DW +: DW], 32'h1);
    idle();

    // R9 unmapped
    drive_b(0, 8'h24, 4'hF, 0, 0, "R9 ch15 offset 0x24 reads zero");
    chk("R9 ch15 offset 0x24 no select", 32'(ch_sel), 0);
    idle();
    drive_a(0, 12'h0A4, 4'hF, 0, 0, "R9 ch0 offset 0xA4 reads zero");
    idle();
    drive_a(0, 12'h302, 4'hF, 0, 0, "R9 unaligned reads zero");
    chk("R9 unaligned no select", 32'(ch_sel), 0);
    idle();
    drive_a(0, 12'hF40, 4'hF, 0, 0, "R9 global gap reads zero");
    idle();

    // R5 R10 interrupt view
    ch_irq = 16'h8021;
    #1 chk("R10 irq_any high", 32'(irq_any), 1);
    drive_a(0, 12'hFE0, 4'hF, 0, 32'h0000_8021, "R5 irq status read");
    idle();
    drive_a(1, 12'hFE0, 4'hF, 32'hFFFF_FFFF, 0, "");
    idle();
    chk("R5 status write leaves enables", 32'(chan_en), 32'hFFFF);
    drive_a(0, 12'hFE0, 4'hF, 0, 32'h0000_8021, "R5 status unchanged by write");
    idle();

    // R6 enable register
    drive_a(1, 12'hFF0, 4'hF, 32'hABCD_1234, 0, "");
    idle();
    chk("R6 enable keeps low half", 32'(chan_en), 32'h1234);
    drive_a(0, 12'hFF0, 4'hF, 0, 32'h0000_1234, "R6 enable readback");
    idle();

    // R8 partial accesses
    drive_a(1, 12'hFF0, 4'h3, 32'h0, 0, "");
    chk("R8 partial write no strobe", 32'(ch_wr), 0);
    idle();
    chk("R8 partial write leaves enables", 32'(chan_en), 32'h1234);
    drive_a(0, 12'h314, 4'h7, 0, 0, "R8 partial read zero");
    chk("R8 partial read no select", 32'(ch_sel), 0);
    idle();
    drive_b(1, 8'h04, 4'hE, 32'h5, 0, "");
    chk("R8 partial ch15 write no strobe", 32'(ch_wr), 0);
    idle();

    // both ports together
    @(negedge clk);
    a_sel = 1; a_wr = 0; a_addr = 12'h710; a_be = 4'hF;
    b_sel = 1; b_wr = 0; b_addr = 8'h10; b_be = 4'hF;
    qa_exp.push_back(cw(7, 8'h10));  qa_tag.push_back("R4 concurrent main read");
    qb_exp.push_back(cw(15, 8'h10)); qb_tag.push_back("R7 concurrent ch15 read");
    #1 chk("R2 concurrent selects", 32'(ch_sel), 32'h8080);
    idle();

    ch_irq = '0;
    #1 chk("R10 irq_any low", 32'(irq_any), 0);
    repeat (2) @(negedge clk);
    chk("R4 all reads answered", 32'(qa_exp.size() + qb_exp.size()), 0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule